// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits between a small host processor and a parallel NOR flash device with a 22-bit address bus and a 16-bit data bus. When the host is not asking for anything, the block is in read mode. It applies the host address to the flash and drives the pins for a read, so array data comes straight back to the host. It keeps chip enable low at all times and selects 16-bit word mode.

A host program request starts a word program. The block issues three fixed unlock bus cycles and then waits for the host write strobe. The strobe supplies the target address and data for the fourth, data-carrying cycle. A host erase request starts a chip erase, which is a chain of six fixed command cycles. Each bus cycle takes three clocks: setup, write-enable low, and write-enable high. The flash takes the address on the falling edge of write enable and the data on the rising edge. Busy and done report progress to the host. After an erase, busy also covers the time the flash holds its ready/busy pin low.

Top module: `nor_cmd_seq`

## Requirements
- R1: While idle, the outputs are set for a read: flash_oe_n=0, flash_we_n=1, flash_ce_n=0 and flash_byte_n=1. The data bus is released (flash_dq_oe=0), flash_addr equals host_addr, and host_rdata equals flash_dq_i.
- R2: A program starts only on the falling edge of prog_req, seen as 1 on one clock and 0 on the next. busy is 1 from the clock after that edge. If prog_req and erase_req fall on the same clock, the program wins.
- R3: A program issues three unlock cycles in order: address 0x555 with data 0xAA, then 0x2AA with 0x55, then 0x555 with 0xA0.
- R4: After the unlock cycles, busy stays 1 and flash_we_n stays 1 until wr_stb falls. The next cycle then carries the host_addr and host_wdata that were present at that edge.
- R5: An erase starts on the falling edge of erase_req. It issues six cycles in order: 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, 0x555/0x10.
- R6: Each bus cycle lasts exactly three clocks, with flash_we_n low only in the middle clock. flash_addr and flash_dq_o hold the same value in the clock before flash_we_n falls and in the clock in which it rises.
- R7: During a command, flash_oe_n is 1. While a cycle runs or while waiting for the write strobe, the data bus is driven (flash_dq_oe=1).
- R8: While busy, prog_req and erase_req edges are ignored. No extra bus cycle is issued.
- R9: After the sixth erase cycle, busy stays 1 for as long as flash_ready is 0. The block returns to idle on the first clock with flash_ready=1.
- R10: done is a single-clock pulse, seen on the first idle clock after a program or an erase ends.
- R11: A wr_stb edge while idle has no effect: no write-enable pulse, and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_req | input | 1 | Program request, acts on its falling edge |
| erase_req | input | 1 | Chip erase request, acts on its falling edge |
| wr_stb | input | 1 | Final program write strobe, acts on its falling edge |
| host_addr | input | 22 | Host word address |
| host_wdata | input | 16 | Host program data |
| host_rdata | output | 16 | Read data returned to host |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock completion pulse |
| flash_addr | output | 22 | Flash address bus |
| flash_dq_o | output | 16 | Flash data bus, driven value |
| flash_dq_oe | output | 1 | Data bus drive enable |
| flash_dq_i | input | 16 | Flash data bus, received value |
| flash_ce_n | output | 1 | Chip enable, always low |
| flash_oe_n | output | 1 | Output enable |
| flash_we_n | output | 1 | Write enable |
| flash_byte_n | output | 1 | Word-mode select, always high |
| flash_ready | input | 1 | Ready/busy from the flash, 1 = ready |

## Verification
Two situations are hard to reach from the ports. The first is the pause between the third unlock cycle and the host write. The second is the tail of an erase, where the flash holds its ready pin low. To reach the pause, the bench watches write-enable pulses until it has counted three. It then stays idle for several clocks and fires stray program and erase requests before giving the write strobe. For the erase tail, the bench acts as the flash: it pulls flash_ready low as soon as the sixth pulse appears, checks that busy stays up for a stretch of clocks, and then releases it.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [1:0] {
        M_IDLE    = 2'd0,
        M_RUN     = 2'd1,
        M_WAITWR  = 2'd2,
        M_ERSWAIT = 2'd3
    } seq_mode_e;

    localparam int CMD_AW = 11;
    localparam int CMD_DW = 8;

    localparam logic [CMD_AW-1:0] UNLK_A1 = 11'h555;
    localparam logic [CMD_AW-1:0] UNLK_A2 = 11'h2AA;
    localparam logic [CMD_DW-1:0] UNLK_D1 = 8'hAA;
    localparam logic [CMD_DW-1:0] UNLK_D2 = 8'h55;
    localparam logic [CMD_DW-1:0] SETUP_PROG = 8'hA0;
    localparam logic [CMD_DW-1:0] SETUP_ERS  = 8'h80;
    localparam logic [CMD_DW-1:0] GO_CHIP_ERS = 8'h10;

    localparam int PH_LAST = 2;

endpackage

// File: rtl/nor_seq_edge.sv
module nor_seq_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] fall
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic prev_d, prev_q;

        always_comb begin
            prev_d = sig[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= prev_d;
        end

        assign fall[i] = prev_q & ~sig[i];
    end

endmodule

// File: rtl/nor_seq_cmdtab.sv
module nor_seq_cmdtab
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic [2:0]        step,
    input  logic              is_erase,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);

    logic [CMD_AW-1:0] a_s;
    logic [CMD_DW-1:0] d_s;

    always_comb begin
        unique case (step)
            3'd0:    begin a_s = UNLK_A1; d_s = UNLK_D1; end
            3'd1:    begin a_s = UNLK_A2; d_s = UNLK_D2; end
            3'd2:    begin a_s = UNLK_A1; d_s = is_erase ? SETUP_ERS : SETUP_PROG; end
            3'd3:    begin a_s = UNLK_A1; d_s = UNLK_D1; end
            3'd4:    begin a_s = UNLK_A2; d_s = UNLK_D2; end
            3'd5:    begin a_s = UNLK_A1; d_s = GO_CHIP_ERS; end
            default: begin a_s = '0;      d_s = '0; end
        endcase
        cmd_addr = {{(ADDR_W-CMD_AW){1'b0}}, a_s};
        cmd_data = {{(DATA_W-CMD_DW){1'b0}}, d_s};
    end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_req,
    input  logic              erase_req,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [DATA_W-1:0] flash_dq_o,
    output logic              flash_dq_oe,
    input  logic [DATA_W-1:0] flash_dq_i,
    output logic              flash_ce_n,
    output logic              flash_oe_n,
    output logic              flash_we_n,
    output logic              flash_byte_n,
    input  logic              flash_ready
);

    localparam int N_STB     = 3;
    localparam int IDX_PROG  = 0;
    localparam int IDX_ERS   = 1;
    localparam int IDX_WR    = 2;
    localparam logic [2:0] PROG_PAUSE = 3'd2;
    localparam logic [2:0] PROG_LAST  = 3'd3;
    localparam logic [2:0] ERS_LAST   = 3'd5;

    typedef struct packed {
        seq_mode_e         mode;
        logic              is_erase;
        logic [2:0]        step;
        logic [1:0]        ph;
        logic [ADDR_W-1:0] lat_addr;
        logic [DATA_W-1:0] lat_data;
        logic              done;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic [N_STB-1:0]  fall;
    logic [ADDR_W-1:0] tab_addr;
    logic [DATA_W-1:0] tab_data;
    logic              use_host;

    nor_seq_edge #(.N(N_STB)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({wr_stb, erase_req, prog_req}),
        .fall  (fall)
    );

    nor_seq_cmdtab #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tab (
        .step     (st_q.step),
        .is_erase (st_q.is_erase),
        .cmd_addr (tab_addr),
        .cmd_data (tab_data)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.mode)
            M_IDLE: begin
                if (fall[IDX_PROG] || fall[IDX_ERS]) begin
                    st_d.mode     = M_RUN;
                    st_d.is_erase = !fall[IDX_PROG];
                    st_d.step     = '0;
                    st_d.ph       = '0;
                end
            end
            M_RUN: begin
                if (st_q.ph != 2'(PH_LAST)) begin
                    st_d.ph = st_q.ph + 2'd1;
                end else begin
                    st_d.ph = '0;
                    if (!st_q.is_erase && st_q.step == PROG_PAUSE) begin
                        st_d.mode = M_WAITWR;
                    end else if (!st_q.is_erase && st_q.step == PROG_LAST) begin
                        st_d.mode = M_IDLE;
                        st_d.done = 1'b1;
                    end else if (st_q.is_erase && st_q.step == ERS_LAST) begin
                        st_d.mode = M_ERSWAIT;
                    end else begin
                        st_d.step = st_q.step + 3'd1;
                    end
                end
            end
            M_WAITWR: begin
                if (fall[IDX_WR]) begin
                    st_d.mode     = M_RUN;
                    st_d.step     = PROG_LAST;
                    st_d.ph       = '0;
                    st_d.lat_addr = host_addr;
                    st_d.lat_data = host_wdata;
                end
            end
            M_ERSWAIT: begin
                if (flash_ready) begin
                    st_d.mode = M_IDLE;
                    st_d.done = 1'b1;
                end
            end
            default: st_d.mode = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: M_IDLE, is_erase: 1'b0, step: '0, ph: '0,
                      lat_addr: '0, lat_data: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign use_host     = (st_q.mode == M_RUN) && !st_q.is_erase && (st_q.step == PROG_LAST);
    assign busy         = (st_q.mode != M_IDLE);
    assign done         = st_q.done;
    assign flash_ce_n   = 1'b0;
    assign flash_byte_n = 1'b1;
    assign flash_oe_n   = busy;
    assign flash_we_n   = !((st_q.mode == M_RUN) && st_q.ph[0]);
    assign flash_dq_oe  = (st_q.mode == M_RUN) || (st_q.mode == M_WAITWR);
    assign flash_addr   = use_host ? st_q.lat_addr :
                          (st_q.mode == M_RUN) ? tab_addr : host_addr;
    assign flash_dq_o   = use_host ? st_q.lat_data :
                          (st_q.mode == M_RUN) ? tab_data : host_wdata;
    assign host_rdata   = flash_dq_i;

    AST_READ_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!flash_oe_n && flash_we_n && !flash_dq_oe)); // R1
    AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_we_n) |-> ($stable(flash_addr) && $stable(flash_dq_o))); // R6
    AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we_n) |-> ($stable(flash_addr) && $stable(flash_dq_o))); // R6
    AST_WE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n |=> flash_we_n); // R6
    AST_CMD_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n |-> (flash_oe_n && flash_dq_oe)); // R7
    AST_ERS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_ERSWAIT && !flash_ready) |=> busy); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10

endmodule

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_req = 1'b0, erase_req = 1'b0, wr_stb = 1'b0;
    logic [21:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        busy, done;
    logic [21:0] flash_addr;
    logic [15:0] flash_dq_o;
    logic        flash_dq_oe;
    logic [15:0] flash_dq_i = '0;
    logic        flash_ce_n, flash_oe_n, flash_we_n, flash_byte_n;
    logic        flash_ready = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int cap_n = 0;
    logic [21:0] cap_a [256];
    logic [15:0] cap_d [256];
    int          cap_t [256];

    localparam logic [21:0] T_ADDR [3] = '{22'h01_2345, 22'h3F_FFFF, 22'h00_0000};
    localparam logic [15:0] T_DATA [3] = '{16'hBEEF, 16'h0000, 16'hFFFF};
    localparam logic [21:0] E_ADDR [6] = '{22'h555, 22'h2AA, 22'h555, 22'h555, 22'h2AA, 22'h555};
    localparam logic [15:0] E_DATA [6] = '{16'hAA, 16'h55, 16'h80, 16'hAA, 16'h55, 16'h10};
    localparam logic [21:0] U_ADDR [3] = '{22'h555, 22'h2AA, 22'h555};
    localparam logic [15:0] U_DATA [3] = '{16'hAA, 16'h55, 16'hA0};

    always #2 clk = ~clk;

    nor_cmd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .erase_req(erase_req),
        .wr_stb(wr_stb), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .busy(busy), .done(done),
        .flash_addr(flash_addr), .flash_dq_o(flash_dq_o), .flash_dq_oe(flash_dq_oe),
        .flash_dq_i(flash_dq_i), .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
        .flash_we_n(flash_we_n), .flash_byte_n(flash_byte_n), .flash_ready(flash_ready)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && !flash_we_n && cap_n < 256) begin
            cap_a[cap_n] <= flash_addr;
            cap_d[cap_n] <= flash_dq_o;
            cap_t[cap_n] <= cyc;
            cap_n <= cap_n + 1;
        end
    end

    function automatic void chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic settle();
        @(negedge clk); #0;
    endtask

    task automatic wait_caps(input int target);
        for (int k = 0; k < 200 && cap_n < target; k++) settle();
        #0;
    endtask

    task automatic wait_done(input string tag);
        int k;
        for (k = 0; k < 200 && !done; k++) settle();
        chk(done === 1'b1, tag, 32'(done), 32'd1);
        settle();
        chk(done === 1'b0 && busy === 1'b0, "R10 done one clock", {30'd0, done, busy}, 32'd0);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int base;
        repeat (3) tick();
        rst_n = 1'b1;
        host_addr = 22'h2A_5A5A;
        flash_dq_i = 16'hC3C3;
        settle();
        // R1: reset / idle read pins
        chk(busy === 1'b0 && done === 1'b0, "R1 idle busy/done", {30'd0, busy, done}, 32'd0);
        chk(flash_oe_n === 1'b0 && flash_we_n === 1'b1 && flash_ce_n === 1'b0 && flash_byte_n === 1'b1,
            "R1 read pins", {28'd0, flash_oe_n, flash_we_n, flash_ce_n, flash_byte_n}, 32'b0101);
        chk(flash_dq_oe === 1'b0, "R1 bus released", 32'(flash_dq_oe), 32'd0);
        chk(flash_addr === host_addr && host_rdata === 16'hC3C3, "R1 passthrough",
            {10'd0, flash_addr}, {10'd0, host_addr});

        // R11: write strobe in idle ignored
        base = cap_n;
        wr_stb = 1'b1; tick(); wr_stb = 1'b0;
        repeat (6) settle();
        chk(cap_n == base && busy === 1'b0, "R11 idle strobe", 32'(cap_n - base), 32'd0);

        // R2-R4, R6-R8: table of program operations
        for (int i = 0; i < 3; i++) begin
            base = cap_n;
            prog_req = 1'b1; tick();
            settle();
            chk(busy === 1'b0, "R2 no start on high level", 32'(busy), 32'd0);
            tick(); prog_req = 1'b0;
            settle();
            chk(busy === 1'b0, "R2 pre-edge", 32'(busy), 32'd0);
            settle();
            chk(busy === 1'b1 && flash_oe_n === 1'b1, "R2 busy after fall", {30'd0, busy, flash_oe_n}, 32'd3);
            wait_caps(base + 3);
            for (int j = 0; j < 3; j++) begin
                chk(cap_a[base+j] === U_ADDR[j] && cap_d[base+j] === U_DATA[j], "R3 unlock word",
                    {cap_a[base+j][15:0], cap_d[base+j]}, {U_ADDR[j][15:0], U_DATA[j]});
            end
            chk(cap_t[base+1] - cap_t[base] == 3 && cap_t[base+2] - cap_t[base+1] == 3,
                "R6 cycle length", 32'(cap_t[base+1] - cap_t[base]), 32'd3);
            if (i == 1) begin
                erase_req = 1'b1; tick(); erase_req = 1'b0;
                prog_req = 1'b1; tick(); prog_req = 1'b0;
            end
            repeat (8) settle();
            chk(cap_n == base + 3 && busy === 1'b1 && flash_we_n === 1'b1 && flash_dq_oe === 1'b1,
                "R4 R8 pause holds", 32'(cap_n - base), 32'd3);
            host_addr = T_ADDR[i];
            host_wdata = T_DATA[i];
            wr_stb = 1'b1; tick(); wr_stb = 1'b0;
            tick();
            host_addr = 22'h11_1111; host_wdata = 16'h2222;
            wait_done("R10 program done");
            chk(cap_n == base + 4, "R4 four cycles", 32'(cap_n - base), 32'd4);
            chk(cap_a[base+3] === T_ADDR[i] && cap_d[base+3] === T_DATA[i], "R4 data cycle",
                {cap_a[base+3][15:0], cap_d[base+3]}, {T_ADDR[i][15:0], T_DATA[i]});
        end

        // R5, R9, R8: chip erase with ready held low
        base = cap_n;
        erase_req = 1'b1; tick(); erase_req = 1'b0;
        tick();
        prog_req = 1'b1; tick(); prog_req = 1'b0;
        wait_caps(base + 6);
        flash_ready = 1'b0;
        for (int j = 0; j < 6; j++) begin
            chk(cap_a[base+j] === E_ADDR[j] && cap_d[base+j] === E_DATA[j], "R5 erase word",
                {cap_a[base+j][15:0], cap_d[base+j]}, {E_ADDR[j][15:0], E_DATA[j]});
        end
        chk(cap_t[base+5] - cap_t[base] == 15, "R6 erase spacing", 32'(cap_t[base+5] - cap_t[base]), 32'd15);
        repeat (20) settle();
        chk(busy === 1'b1 && done === 1'b0 && cap_n == base + 6, "R9 R8 busy while not ready",
            {30'd0, busy, done}, 32'd2);
        flash_ready = 1'b1;
        wait_done("R9 erase done");

        // R2: simultaneous falls, program wins
        base = cap_n;
        prog_req = 1'b1; erase_req = 1'b1; tick(); prog_req = 1'b0; erase_req = 1'b0;
        wait_caps(base + 3);
        repeat (6) settle();
        chk(cap_n == base + 3 && cap_d[base+2] === 16'hA0, "R2 program priority",
            {16'd0, cap_d[base+2]}, 32'hA0);
        host_addr = 22'h00_0ABC; host_wdata = 16'h1357;
        wr_stb = 1'b1; tick(); wr_stb = 1'b0;
        wait_done("R10 priority done");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule